// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This peripheral holds four independent 16-bit timing channels behind one 16-bit register port. Each channel counts ticks from its own prescaler. It can restart its count when the count equals one of four general compare values, and it drives one output pin. The pin starts from a programmed initial level and changes by a programmed action when the count equals compare value A. In PWM mode the pin also returns to its initial level whenever the counter restarts. One compare value therefore sets the duty point and a second sets the period.

Software reaches every register through single-cycle write and read strobes on a byte address. Read data is combinational: it is valid in the same cycle as `rd_en` and is zero when no read is made. Each channel is controlled by a two-state machine, CH_HALTED and CH_COUNTING. The bit for the channel in the shared start register moves it between the two states. A write of 1 to that bit takes it from CH_HALTED to CH_COUNTING, and a write of 0 takes it back to CH_HALTED. Any other cycle leaves the channel in its current state. The state register is what the start register reads back.

Top module: `pwm_cm_timer`

## Requirements
- R1: After reset every register reads 0, every channel is in CH_HALTED and every pin is low.
- R2: Address 0x00 is the start register. Writing it sets the state of channel n from bit n (1 = CH_COUNTING, 0 = CH_HALTED), and the register reads back the four states in bits [3:0]. A halted channel keeps its counter and its pin unchanged, except when software writes to them directly.
- R3: Channel n occupies 0x10 + n*0x40. Within a channel the offsets are: 0x00 control, 0x04 mode, 0x08 pin control, 0x0C interrupt enable, 0x10 status, 0x14 counter, and 0x18, 0x1C, 0x20, 0x24 for compare values A, B, C and D. Each register reads back what was last written to it. Other addresses read 0 and ignore writes, and `rdata` is 0 whenever `rd_en` is low.
- R4: Control bits [1:0] set the prescale divisor: 0 = 1, 1 = 4, 2 = 16, 3 = 64. Control bits [4:3] select the tick point within each divided period, which starts from phase 0 when counting begins: 0 = the last clock of the period (so the first tick comes N clocks after start), 1 = the clock at N/2, and 2 or 3 = both points. With divisor 1 every clock is a tick.
- R5: On each tick the counter adds 1 and wraps from 0xFFFF to 0. When it equals the compare value that control bits [7:5] select (1 = A, 2 = B, 5 = C, 6 = D), it goes to 0 instead. Any other code in [7:5] never clears it.
- R6: Pin-control bit 2 is the initial level. Bits [1:0] give the action on a tick while the counter equals A: 0 = none, 1 = drive low, 2 = drive high, 3 = toggle.
- R7: A write to pin control drives the pin to the new bit 2 on the next clock, whatever the channel state and whatever match occurs in the same cycle.
- R8: When mode bits [1:0] equal 2 (PWM mode), a counter clear returns the pin to its initial level, and this takes precedence over the A action. With clear on B and pin code 5, the pin is high for A+1 ticks and low for B-A ticks, a period of B+1. Every other mode code behaves as normal mode, and mode bits [6:4] are stored without effect.
- R9: A write to the counter loads it on the next clock and overrides a tick in the same cycle.
- R10: The interrupt-enable and status registers are plain storage and affect neither counting nor the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when `rd_en` is low |
| pin_out | output | 4 | Pin of each channel, bit n for channel n |

## Verification
A corrupted channel state or prescaler phase shows up first as a counter readback that changes too early or too late. A single read one clock after the expected tick exposes it. A wrong counter value or a wrong compare path moves the pin edges. The reference model compares every pin on every clock, so the first misplaced edge is reported in the same cycle it occurs. A wrong pin-control or clear-priority decision shows as a changed duty count within one PWM period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Width of the prescale phase counter (largest divisor is 64)
    localparam int PSC_W     = 6;
    localparam int CH_BASE   = 16;
    localparam int CH_STRIDE = 64;

    // Register offsets inside one channel window
    localparam logic [5:0] OFF_CTRL = 6'h00;
    localparam logic [5:0] OFF_MODE = 6'h04;
    localparam logic [5:0] OFF_IOC  = 6'h08;
    localparam logic [5:0] OFF_IEN  = 6'h0C;
    localparam logic [5:0] OFF_STAT = 6'h10;
    localparam logic [5:0] OFF_CNT  = 6'h14;
    localparam logic [5:0] OFF_GRA  = 6'h18;
    localparam logic [5:0] OFF_GRB  = 6'h1C;
    localparam logic [5:0] OFF_GRC  = 6'h20;
    localparam logic [5:0] OFF_GRD  = 6'h24;

    typedef enum logic {
        CH_HALTED   = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_END  = 2'd0,
        EDGE_MID  = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_ALT  = 2'd3
    } tick_pt_e;

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
    import pwmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    input  logic [1:0] pt_sel,
    output logic       tick
);

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] last_ph;
    logic [PSC_W-1:0] mid_ph;

    // Last phase and half-way phase of the divided period
    always_comb begin
        unique case (div_sel)
            2'd0:    begin last_ph = PSC_W'(0);  mid_ph = PSC_W'(0);  end
            2'd1:    begin last_ph = PSC_W'(3);  mid_ph = PSC_W'(1);  end
            2'd2:    begin last_ph = PSC_W'(15); mid_ph = PSC_W'(7);  end
            default: begin last_ph = PSC_W'(63); mid_ph = PSC_W'(31); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || phase_q >= last_ph) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (run) begin
            if (div_sel == 2'd0) begin
                tick = 1'b1;
            end else begin
                unique case (tick_pt_e'(pt_sel))
                    EDGE_END: tick = (phase_q == last_ph);
                    EDGE_MID: tick = (phase_q == mid_ph);
                    default:  tick = (phase_q == last_ph) || (phase_q == mid_ph);
                endcase
            end
        end
    end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_bit,
    input  logic          reg_wr,
    input  logic [5:0]    reg_off,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rd_val,
    output logic          running,
    output logic          pin,
    output logic [CW-1:0] count
);

    localparam int NGR   = 4;
    localparam int GRI_W = $clog2(NGR);

    ch_state_e     state_q, state_d;
    logic [CW-1:0] ctrl_q, mode_q, ioc_q, ien_q, stat_q;
    logic [CW-1:0] gr_q [NGR];
    logic          tick, pwm_mode, clr_en, clr_hit, a_hit;
    logic [GRI_W-1:0] clr_idx;
    pin_act_e      act;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HALTED;
        else        state_q <= state_d;
    end

    // Transitions: START (HALTED->COUNTING), STOP (COUNTING->HALTED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALTED:   if (start_wr && start_bit)  state_d = CH_COUNTING;
            CH_COUNTING: if (start_wr && !start_bit) state_d = CH_HALTED;
        endcase
    end

    assign running = (state_q == CH_COUNTING);

    // Configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            for (int g = 0; g < NGR; g++) gr_q[g] <= '0;
        end else if (reg_wr) begin
            case (reg_off)
                OFF_CTRL: ctrl_q   <= wdata;
                OFF_MODE: mode_q   <= wdata;
                OFF_IOC:  ioc_q    <= wdata;
                OFF_IEN:  ien_q    <= wdata;
                OFF_STAT: stat_q   <= wdata;
                OFF_GRA:  gr_q[0]  <= wdata;
                OFF_GRB:  gr_q[1]  <= wdata;
                OFF_GRC:  gr_q[2]  <= wdata;
                OFF_GRD:  gr_q[3]  <= wdata;
                default: ;
            endcase
        end
    end

    pwmt_prescale u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .div_sel (ctrl_q[1:0]),
        .pt_sel  (ctrl_q[4:3]),
        .tick    (tick)
    );

    // Clear-source selection
    always_comb begin
        clr_en  = 1'b1;
        clr_idx = '0;
        case (ctrl_q[7:5])
            3'd1:    clr_idx = GRI_W'(0);
            3'd2:    clr_idx = GRI_W'(1);
            3'd5:    clr_idx = GRI_W'(2);
            3'd6:    clr_idx = GRI_W'(3);
            default: clr_en  = 1'b0;
        endcase
    end

    assign clr_hit  = tick && clr_en && (count == gr_q[clr_idx]);
    assign a_hit    = tick && (count == gr_q[0]);
    assign pwm_mode = (mode_q[1:0] == 2'd2);
    assign act      = pin_act_e'(ioc_q[1:0]);

    // Outputs: counter and pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pin   <= 1'b0;
        end else begin
            if (reg_wr && reg_off == OFF_CNT) count <= wdata;
            else if (tick)                    count <= clr_hit ? '0 : count + 1'b1;

            if (reg_wr && reg_off == OFF_IOC) begin
                pin <= wdata[2];
            end else if (pwm_mode && clr_hit) begin
                pin <= ioc_q[2];
            end else if (a_hit) begin
                unique case (act)
                    ACT_NONE:   pin <= pin;
                    ACT_LOW:    pin <= 1'b0;
                    ACT_HIGH:   pin <= 1'b1;
                    ACT_TOGGLE: pin <= ~pin;
                endcase
            end
        end
    end

    // Read-back
    always_comb begin
        case (reg_off)
            OFF_CTRL: rd_val = ctrl_q;
            OFF_MODE: rd_val = mode_q;
            OFF_IOC:  rd_val = ioc_q;
            OFF_IEN:  rd_val = ien_q;
            OFF_STAT: rd_val = stat_q;
            OFF_CNT:  rd_val = count;
            OFF_GRA:  rd_val = gr_q[0];
            OFF_GRB:  rd_val = gr_q[1];
            OFF_GRC:  rd_val = gr_q[2];
            OFF_GRD:  rd_val = gr_q[3];
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/pwm_cm_timer.sv
module pwm_cm_timer
    import pwmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = 16,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    output logic [NUM_CH-1:0] pin_out
);

    localparam int CHW = AW - 6;

    logic [AW-1:0]             rel;
    logic                      in_ch;
    logic [CHW-1:0]            ch_idx;
    logic [5:0]                off;
    logic                      start_wr;
    logic [NUM_CH-1:0]         running;
    logic [NUM_CH-1:0][CW-1:0] rd_bus;
    logic [NUM_CH-1:0][CW-1:0] cnt_bus;

    assign rel      = addr - AW'(CH_BASE);
    assign in_ch    = (addr >= AW'(CH_BASE));
    assign ch_idx   = rel[AW-1:6];
    assign off      = rel[5:0];
    assign start_wr = wr_en && (addr == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = in_ch && (ch_idx == CHW'(c));

        pwmt_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_wr  (start_wr),
            .start_bit (wdata[c]),
            .reg_wr    (wr_en && sel),
            .reg_off   (off),
            .wdata     (wdata),
            .rd_val    (rd_bus[c]),
            .running   (running[c]),
            .pin       (pin_out[c]),
            .count     (cnt_bus[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == '0) begin
                rdata = CW'(running);
            end else if (in_ch) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_idx == CHW'(c)) rdata = rd_bus[c];
                end
            end
        end
    end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = 16,
    parameter int AW     = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             addr,
    input logic [CW-1:0]             wdata,
    input logic [NUM_CH-1:0]         running,
    input logic [NUM_CH-1:0]         pin_out,
    input logic [NUM_CH-1:0][CW-1:0] cnt_bus
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [AW-1:0] IOC_A = AW'(CH_BASE + c*CH_STRIDE + 8);
        localparam logic [AW-1:0] CNT_A = AW'(CH_BASE + c*CH_STRIDE + 20);

        // R2
        start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == '0) |=> (running[c] == $past(wdata[c])));

        // R2
        halt_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[c] && !(wr_en && addr == CNT_A)) |=> (cnt_bus[c] == $past(cnt_bus[c])));

        // R2
        halt_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[c] && !(wr_en && addr == IOC_A)) |=> $stable(pin_out[c]));

        // R7
        ioc_write_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == IOC_A) |=> (pin_out[c] == $past(wdata[2])));

        // R9
        cnt_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CNT_A) |=> (cnt_bus[c] == $past(wdata)));

        // R5
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (running[c] && !(wr_en && addr == CNT_A)) |=>
            (cnt_bus[c] == $past(cnt_bus[c]) || cnt_bus[c] == CW'($past(cnt_bus[c]) + 1'b1)
             || cnt_bus[c] == '0));
    end

endmodule

bind pwm_cm_timer pwmt_checker #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .running (running),
    .pin_out (pin_out),
    .cnt_bus (cnt_bus)
);

// File: tb/test_pwm_cm_timer.sv
module test_pwm_cm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pin_out;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [15:0] rd_last;

    // Reference model state
    bit [15:0] m_ctrl[4], m_mode[4], m_ioc[4], m_ien[4], m_stat[4], m_cnt[4];
    bit [15:0] m_gr[4][4];
    bit        m_run[4], m_pin[4];
    int        m_pc[4];

    pwm_cm_timer i_pwm_cm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_out(pin_out)
    );

    always #10 clk = ~clk;

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_ctrl[c] = 0; m_mode[c] = 0; m_ioc[c] = 0; m_ien[c] = 0; m_stat[c] = 0;
            m_cnt[c] = 0; m_run[c] = 0; m_pin[c] = 0; m_pc[c] = 0;
            for (int g = 0; g < 4; g++) m_gr[c][g] = 0;
        end
    endtask

    task automatic model_step();
        for (int c = 0; c < 4; c++) begin
            int n = 1 << (2 * int'(m_ctrl[c][1:0]));
            int lim = n - 1;
            int mid = n / 2 - 1;
            bit [1:0] pt = m_ctrl[c][4:3];
            bit tk = 0, en = 1, chit, ahit;
            int idx = 0;
            bit [7:0] base = 8'(16 + c * 64);
            if (m_run[c]) begin
                if (n == 1)       tk = 1;
                else if (pt == 0) tk = (m_pc[c] == lim);
                else if (pt == 1) tk = (m_pc[c] == mid);
                else              tk = (m_pc[c] == lim) || (m_pc[c] == mid);
            end
            m_pc[c] = (!m_run[c] || m_pc[c] >= lim) ? 0 : m_pc[c] + 1;
            case (m_ctrl[c][7:5])
                3'd1: idx = 0; 3'd2: idx = 1; 3'd5: idx = 2; 3'd6: idx = 3;
                default: en = 0;
            endcase
            chit = tk && en && (m_cnt[c] == m_gr[c][idx]);
            ahit = tk && (m_cnt[c] == m_gr[c][0]);
            if (m_mode[c][1:0] == 2 && chit) m_pin[c] = m_ioc[c][2];
            else if (ahit) begin
                case (m_ioc[c][1:0])
                    2'd1: m_pin[c] = 0;
                    2'd2: m_pin[c] = 1;
                    2'd3: m_pin[c] = ~m_pin[c];
                    default: ;
                endcase
            end
            if (tk) m_cnt[c] = chit ? 16'd0 : m_cnt[c] + 16'd1;
            if (wr_en && addr == 0) m_run[c] = wdata[c];
            if (wr_en && addr >= base && addr < base + 8'h28) begin
                case (addr - base)
                    8'h00: m_ctrl[c] = wdata;
                    8'h04: m_mode[c] = wdata;
                    8'h08: begin m_ioc[c] = wdata; m_pin[c] = wdata[2]; end
                    8'h0C: m_ien[c] = wdata;
                    8'h10: m_stat[c] = wdata;
                    8'h14: m_cnt[c] = wdata;
                    8'h18: m_gr[c][0] = wdata;
                    8'h1C: m_gr[c][1] = wdata;
                    8'h20: m_gr[c][2] = wdata;
                    8'h24: m_gr[c][3] = wdata;
                    default: ;
                endcase
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    function automatic bit [15:0] exp_read(bit [7:0] a);
        int c, o;
        if (a == 0) return {12'd0, m_run[3], m_run[2], m_run[1], m_run[0]};
        if (a < 16) return 0;
        c = (a - 16) / 64; o = (a - 16) % 64;
        case (o)
            'h00: return m_ctrl[c];  'h04: return m_mode[c];
            'h08: return m_ioc[c];   'h0C: return m_ien[c];
            'h10: return m_stat[c];  'h14: return m_cnt[c];
            'h18: return m_gr[c][0]; 'h1C: return m_gr[c][1];
            'h20: return m_gr[c][2]; 'h24: return m_gr[c][3];
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(bit [7:0] a);
        int o = (a - 16) % 64;
        if (a == 0) return "R2";
        if (a < 16 || o >= 'h28) return "R3";
        if (o == 'h14) return "R5";
        if (o == 'h0C || o == 'h10) return "R10";
        return "R3";
    endfunction

    // One bus cycle: check pins, drive inputs, check read data
    task automatic step(bit w, bit r, logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        for (int c = 0; c < 4; c++)
            chk(pin_out[c] == m_pin[c], (m_mode[c][1:0] == 2) ? "R8" : "R6",
                16'(pin_out[c]), 16'(m_pin[c]));
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        rd_last = rdata;
        if (r) chk(rdata == exp_read(a), req_of(a), rdata, exp_read(a));
        else   chk(rdata == 0, "R3", rdata, 16'd0);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d); step(1, 0, a, d); endtask
    task automatic rd(logic [7:0] a); step(0, 1, a, 16'd0); endtask

    function automatic logic [15:0] rand_data(int o);
        case (o)
            'h00: return {8'($urandom), 3'($urandom), 2'($urandom), 1'b0,
                          ($urandom % 4 == 0) ? 2'($urandom) : 2'd0};
            'h04: return (($urandom % 2) ? 16'd2 : 16'd0) | (16'($urandom) & 16'h0070);
            'h08: return 16'($urandom % 8);
            'h14: return ($urandom % 8 == 0) ? 16'hFFFE : 16'($urandom % 16);
            'h18, 'h1C, 'h20, 'h24: return 16'($urandom % 16);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(pin_out == 4'd0, "R1", 16'(pin_out), 16'd0);
        rd(8'h00); chk(rd_last == 0, "R1", rd_last, 16'd0);
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 'h28; o += 4) begin
                rd(8'(16 + c * 64 + o));
                chk(rd_last == 0, "R1", rd_last, 16'd0);
            end

        // R7: pin-control write on a halted channel
        wr(8'hD8, 16'h0004);
        rd(8'h00);
        chk(pin_out[3] == 1'b1, "R7", 16'(pin_out[3]), 16'd1);

        // R9: counter write
        wr(8'hE4, 16'h1234);
        rd(8'hE4);
        chk(rd_last == 16'h1234, "R9", rd_last, 16'h1234);
        wr(8'hD8, 16'h0000);

        // R4: divide by 4, tick at end of period
        wr(8'h90, 16'h0001);
        wr(8'h00, 16'h0004);
        for (int k = 1; k <= 5; k++) begin
            rd(8'hA4);
            if (k == 4) chk(rd_last == 0, "R4", rd_last, 16'd0);
            if (k == 5) chk(rd_last == 1, "R4", rd_last, 16'd1);
        end

        // R8: PWM on channel 1, clear on B=5, A=1
        wr(8'h50, 16'h0040);
        wr(8'h54, 16'h0002);
        wr(8'h68, 16'h0001);
        wr(8'h6C, 16'h0005);
        wr(8'h58, 16'h0005);
        wr(8'h00, 16'h0006);
        begin
            int hi = 0;
            repeat (6) rd(8'h64);
            for (int k = 0; k < 24; k++) begin rd(8'h64); hi += pin_out[1]; end
            chk(hi == 8, "R8", 16'(hi), 16'd8);
            wr(8'h58, 16'h0002);
            hi = 0;
            repeat (6) rd(8'h64);
            for (int k = 0; k < 24; k++) begin rd(8'h64); hi += pin_out[1]; end
            chk(hi == 16, "R8", 16'(hi), 16'd16);
        end

        // Constrained random traffic against the model
        for (int k = 0; k < 6000; k++) begin
            int pick = $urandom % 24;
            bit [7:0] ra = 8'($urandom);
            if (pick == 0) begin
                wr(8'h00, 16'($urandom % 16));
            end else if (pick == 1) begin
                wr(($urandom % 2) ? 8'($urandom % 16) : 8'(16 + ($urandom % 4) * 64 + 'h28 + ($urandom % 6) * 4),
                   16'($urandom));
            end else if (pick < 5) begin
                int c = $urandom % 4;
                int o = ($urandom % 10) * 4;
                wr(8'(16 + c * 64 + o), rand_data(o));
            end else begin
                if ($urandom % 4 != 0) ra = 8'(16 + ($urandom % 4) * 64 + ($urandom % 10) * 4);
                step(0, ($urandom % 8) != 0, ra, 16'd0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule